// File: doc/BRIEF.md
# Strobe-Sequencing Static Memory Controller

This block sits on the host side of an asynchronous static memory. The memory latches its address on the falling edge of an active-low enable strobe. A simple synchronous request port on the host side carries a request, a write flag, an address and write data. For each request the controller produces the enable (E) and write (W) strobe sequence that the memory expects. Every interval is counted in clock cycles. Each count is derived from a nanosecond minimum and the clock period, rounded up.

A read holds W high. The read data is captured on the clock edge that raises E, which is no earlier than the access time after E fell. A write lowers W on the same edge that lowers E. Write data is driven only after the memory's output-disable time has passed, so a shared data bus is safe. When writes follow one another back to back, W stays low through the E-high recovery while E alone toggles. The memory pins are exposed as plain signals: an output-enable flag and separate data-out and data-in ports replace a tristate driver.

At the default 8 ns clock the derived counts are as follows:
- E low lasts 38 cycles.
- E high recovery lasts 13 cycles.
- Write data is enabled 20 cycles after E falls.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, mem_e_no and mem_w_no are 1, mem_doe_o, rvalid_o are 0 and ready_o is 1.
- R2: A request is accepted on a clock edge where req_i and ready_o are both 1. mem_e_no falls on that same edge, and mem_addr_o shows the accepted address from that edge on. ready_o is 0 whenever mem_e_no is 0, and it returns to 1 only in the last recovery cycle.
- R3: mem_addr_o does not change while mem_e_no stays low.
- R4: mem_e_no stays low for exactly 38 cycles per access. Between accesses it stays high for at least 13 cycles, so the total cycle time is at least 350 ns.
- R5: For a read, mem_w_no is 1 throughout E low. rdata_o takes mem_din_i as sampled on the edge that raises mem_e_no. rvalid_o is a one-cycle pulse in the first E-high cycle. Writes give no rvalid_o.
- R6: For a write, mem_w_no is 0 from the edge that lowers mem_e_no. mem_doe_o becomes 1 exactly 20 cycles after that edge and drops on the edge that raises mem_e_no. mem_dout_o carries the accepted write data while mem_doe_o is 1. mem_doe_o is never 1 while E is high.
- R7: A write accepted in the last recovery cycle after a write keeps mem_w_no low through the whole E-high period. mem_w_no returns to 1 at the end of recovery when a read is accepted there or no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Request can be accepted this cycle |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| rdata_o | output | DW | Read data |
| mem_e_no | output | 1 | Memory enable strobe, active low |
| mem_w_no | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | AW | Memory address |
| mem_dout_o | output | DW | Data toward the memory |
| mem_doe_o | output | 1 | Data-out enable for the shared bus |
| mem_din_i | input | DW | Data from the memory |

## Verification
The bench models the memory from the strobes alone: it latches the address at each E fall and stores the driven data at each E rise while W is low. It exercises the controller with several request patterns, and each one isolates a different behaviour:
- Isolated writes and reads separate each access from its neighbours.
- A four-address burst of writes followed by idle shows that W stays low across E high and then rises when the burst ends.
- A burst of writes followed directly by a read shows that W rises at the E fall of the read.
- Back-to-back reads show the minimum recovery and the timing of the rvalid pulse.

Read-back through the memory model checks that data written at extreme and mixed addresses lands where it should.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCV
  } seq_state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dout_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dout_o <= '0;
    end else if (load_i) begin
      mem_addr_o <= addr_i;
      mem_dout_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= din_i;
  end

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 38,
  parameter int unsigned HIGH_CYC = 13,
  parameter int unsigned DQZ_CYC  = 20,
  parameter int unsigned CW       = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [CW-1:0] cnt_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic          clr_o,
  output logic          capture_o,
  output logic          e_no,
  output logic          w_no,
  output logic          doe_o,
  output logic          rvalid_o
);

  seq_state_e state_q;
  logic       we_q;
  logic       last_low, last_high, doe_on;

  always_comb begin
    last_low  = (cnt_i == CW'(LOW_CYC - 1));
    last_high = (cnt_i == CW'(HIGH_CYC - 1));
    doe_on    = (cnt_i == CW'(DQZ_CYC - 1));
    ready_o   = (state_q == ST_IDLE) || (state_q == ST_RCV && last_high);
    accept_o  = req_i && ready_o;
    capture_o = (state_q == ST_ACT) && last_low && !we_q;
    clr_o     = accept_o || ((state_q == ST_ACT) && last_low);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      e_no     <= 1'b1;
      w_no     <= 1'b1;
      doe_o    <= 1'b0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_o;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q <= ST_ACT;
            e_no    <= 1'b0;
            w_no    <= !we_i;
            we_q    <= we_i;
          end
        end
        ST_ACT: begin
          if (we_q && doe_on) doe_o <= 1'b1;
          if (last_low) begin
            state_q <= ST_RCV;
            e_no    <= 1'b1;
            doe_o   <= 1'b0;
          end
        end
        ST_RCV: begin
          if (last_high) begin
            if (accept_o) begin
              // W stays low when a write follows a write
              state_q <= ST_ACT;
              e_no    <= 1'b0;
              w_no    <= !we_i;
              we_q    <= we_i;
            end else begin
              state_q <= ST_IDLE;
              w_no    <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  ready_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e_no |-> !ready_o);

  // R6
  doe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doe_o |-> (!w_no && !e_no));

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  // R5
  read_w_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(w_no));

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned AW          = 10,
  parameter int unsigned DW          = 1,
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned T_ELOW_NS   = 300,
  parameter int unsigned T_EHIGH_NS  = 100,
  parameter int unsigned T_CYCLE_NS  = 350,
  parameter int unsigned T_ACC_NS    = 300,
  parameter int unsigned T_AHOLD_NS  = 50,
  parameter int unsigned T_WPW_NS    = 130,
  parameter int unsigned T_WSU_NS    = 130,
  parameter int unsigned T_DSU_NS    = 110,
  parameter int unsigned T_DQZ_NS    = 160
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_e_no,
  output logic          mem_w_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dout_o,
  output logic          mem_doe_o,
  input  logic [DW-1:0] mem_din_i
);

  localparam int unsigned DQZ_CYC  = umax(ns2cyc(T_DQZ_NS, CLK_NS), 1);
  localparam int unsigned DSU_CYC  = umax(ns2cyc(T_DSU_NS, CLK_NS), 1);
  localparam int unsigned LOW_CYC  = umax(
      umax(umax(ns2cyc(T_ELOW_NS, CLK_NS), ns2cyc(T_ACC_NS, CLK_NS)),
           umax(ns2cyc(T_WPW_NS, CLK_NS), ns2cyc(T_WSU_NS, CLK_NS))),
      umax(DQZ_CYC + DSU_CYC, ns2cyc(T_AHOLD_NS, CLK_NS) + 1));
  localparam int unsigned CYC_CYC  = ns2cyc(T_CYCLE_NS, CLK_NS);
  localparam int unsigned HIGH_CYC = umax(umax(ns2cyc(T_EHIGH_NS, CLK_NS),
      (CYC_CYC > LOW_CYC) ? CYC_CYC - LOW_CYC : 0), 1);
  localparam int unsigned CW       = $clog2(umax(LOW_CYC, HIGH_CYC) + 1);

  logic [CW-1:0] cnt;
  logic          clr, accept, capture;

  sram_strobe_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  sram_strobe_fsm #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC),
    .DQZ_CYC  (DQZ_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .cnt_i     (cnt),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .clr_o     (clr),
    .capture_o (capture),
    .e_no      (mem_e_no),
    .w_no      (mem_w_no),
    .doe_o     (mem_doe_o),
    .rvalid_o  (rvalid_o)
  );

  sram_strobe_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .capture_i  (capture),
    .din_i      (mem_din_i),
    .mem_addr_o (mem_addr_o),
    .mem_dout_o (mem_dout_o),
    .rdata_o    (rdata_o)
  );

  // checker counter: consecutive E-low cycles
  logic [CW-1:0] elow_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          elow_q <= '0;
    else if (mem_e_no)    elow_q <= '0;
    else if (elow_q != '1) elow_q <= elow_q + 1'b1;
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_e_no && $past(!mem_e_no)) |-> $stable(mem_addr_o));

  // R4
  e_low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_e_no) |-> ($past(elow_q) == CW'(LOW_CYC - 1)));

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

  localparam int LOW_CYC  = 38;
  localparam int HIGH_CYC = 13;
  localparam int DQZ_CYC  = 20;

  typedef struct packed {
    logic [9:0] addr;
    logic       we;
    logic       dat;
    logic       cont;
  } op_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, wdata = 1'b0;
  logic [9:0] addr = '0;
  logic       ready, rvalid, rdata, e_n, w_n, dout, doe, din;
  logic [9:0] maddr;

  always #4 clk = ~clk;

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_e_no(e_n), .mem_w_no(w_n), .mem_addr_o(maddr), .mem_dout_o(dout),
    .mem_doe_o(doe), .mem_din_i(din)
  );

  int   checks = 0, errors = 0;
  op_t  op_q[$];
  logic rd_q[$];
  logic shadow [1024];
  logic model  [1024];
  logic [9:0] lat = '0;

  assign din = (!e_n && w_n) ? model[lat] : 1'b0;

  task automatic chk(input string rq, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [9:0] a, input logic d, input logic cont);
    op_t it;
    it.addr = a; it.we = w; it.dat = d; it.cont = cont;
    op_q.push_back(it);
    if (w) shadow[a] = d;
    else   rd_q.push_back(shadow[a]);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor / scoreboard
  logic prev_e = 1'b1, prev_w = 1'b1, prev_doe = 1'b0, prev_dout = 1'b0, prev_rv = 1'b0;
  int   lowcnt = 0, highcnt = 100;
  bit   w_broke = 1'b1;
  op_t  cur = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!e_n && ready) chk("R2 ready while E low", 0, ready, 0);
      if (prev_e && !e_n) begin
        chk("R4 E high recovery", highcnt >= HIGH_CYC, highcnt, HIGH_CYC);
        if (op_q.size() == 0) chk("R2 unexpected access", 0, 1, 0);
        else begin
          cur = op_q.pop_front();
          chk("R2 address at E fall", maddr == cur.addr, maddr, cur.addr);
          chk("R5/R6 W level at E fall", w_n == !cur.we, w_n, !cur.we);
          if (cur.cont) chk("R7 W low through recovery", !w_broke, w_broke, 0);
        end
        chk("R6 doe off at E fall", !doe, doe, 0);
        lat = maddr;
        lowcnt = 1;
      end else if (!e_n) begin
        lowcnt++;
        chk("R3 address stable", maddr == lat, maddr, lat);
        chk("R6 doe timing", doe == (cur.we && lowcnt >= DQZ_CYC + 1), doe,
            cur.we && lowcnt >= DQZ_CYC + 1);
        chk("R5/R6 W level in E low", w_n == !cur.we, w_n, !cur.we);
      end else if (!prev_e && e_n) begin
        chk("R4 E low length", lowcnt == LOW_CYC, lowcnt, LOW_CYC);
        if (!prev_w) begin
          chk("R6 doe at E rise", prev_doe, prev_doe, 1);
          chk("R6 write data", prev_dout == cur.dat, prev_dout, cur.dat);
          model[lat] = prev_dout;
        end
        chk("R6 doe off in E high", !doe, doe, 0);
        highcnt = 1;
        w_broke = w_n;
      end else begin
        highcnt++;
        if (w_n) w_broke = 1'b1;
        if (doe) chk("R6 doe off in E high", 0, doe, 0);
      end
      if (rvalid) begin
        chk("R5 rvalid timing", highcnt == 1 && !prev_rv && !cur.we, highcnt, 1);
        if (rd_q.size() == 0) chk("R5 unexpected rvalid", 0, 1, 0);
        else begin
          logic e;
          e = rd_q.pop_front();
          chk("R5 read data", rdata == e, rdata, e);
        end
      end
      prev_e = e_n; prev_w = w_n; prev_doe = doe; prev_dout = dout; prev_rv = rvalid;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 0, 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin shadow[i] = 1'b0; model[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 E high", e_n, e_n, 1);
    chk("R1 W high", w_n, w_n, 1);
    chk("R1 doe low", !doe, doe, 0);
    chk("R1 ready high", ready, ready, 1);
    chk("R1 rvalid low", !rvalid, rvalid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // isolated accesses
    do_op(1'b1, 10'd5, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    do_op(1'b0, 10'd5, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    do_op(1'b0, 10'd6, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    do_op(1'b1, 10'd5, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    do_op(1'b0, 10'd5, 1'b0, 1'b0);
    repeat (20) @(negedge clk);

    // R7 burst of writes then idle
    do_op(1'b1, 10'h3FF, 1'b1, 1'b0);
    do_op(1'b1, 10'h000, 1'b0, 1'b1);
    do_op(1'b1, 10'h200, 1'b1, 1'b1);
    do_op(1'b1, 10'h155, 1'b1, 1'b1);
    repeat (70) @(negedge clk);
    chk("R7 W high after burst", w_n, w_n, 1);

    // read back, back to back (R5)
    do_op(1'b0, 10'h3FF, 1'b0, 1'b0);
    do_op(1'b0, 10'h000, 1'b0, 1'b0);
    do_op(1'b0, 10'h200, 1'b0, 1'b0);
    do_op(1'b0, 10'h155, 1'b0, 1'b0);
    repeat (20) @(negedge clk);

    // R7 burst ended by a read
    do_op(1'b1, 10'h0AA, 1'b1, 1'b0);
    do_op(1'b1, 10'h0AB, 1'b1, 1'b1);
    do_op(1'b0, 10'h0AA, 1'b0, 1'b0);
    do_op(1'b0, 10'h0AB, 1'b0, 1'b0);
    do_op(1'b0, 10'h0AC, 1'b0, 1'b0);
    repeat (80) @(negedge clk);

    chk("R2 all accesses seen", op_q.size() == 0, op_q.size(), 0);
    chk("R5 all reads returned", rd_q.size() == 0, rd_q.size(), 0);
    chk("R7 W high when idle", w_n, w_n, 1);
    finish_run();
  end

endmodule